// File: doc/BRIEF.md
# LIN Low-Power Wake Qualifier

This block decides when a single-wire LIN transceiver in its low-power mode has been woken up. It watches two sources: the bus itself, seen as a digitized "bus is dominant" flag from the wake comparator, and an active-low local wake input driven by an external switch. Both inputs are sampled only on a timebase enable (`tick`), so every filter length is a count of ticks. With the default 1 MHz tick, the default of 50 ticks gives the nominal 50 us filter. The parameter can be set anywhere in the 25 to 150 us window.

A remote wake is not a plain debounced level. The bus must first be seen recessive after arming. It must then stay dominant for the full filter time, and the wake is reported only when the bus returns to recessive. A bus shorted to ground therefore never wakes the node. A local wake is reported once the wake input has stayed low for its filter time. Pulses shorter than the filter time on either source are treated as disturbances and dropped.

The mode controller drives `sleep_mode`. The qualifiers are armed only while it is high. When it falls, all progress is discarded at once. Each qualified event produces a registered one-cycle pulse on its own output, so the controller can tell the sources apart. If both sources qualify on the same tick, both pulses are raised together.

Top module: `lin_wake_filter`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `wake_lin` and `wake_local` are 0.
- R2: With `sleep_mode`=1, when `wake_n`=0 has been sampled on LOC_TICKS consecutive ticks, `wake_local` is 1 for exactly one cycle. That cycle is the one following the clock edge that samples the LOC_TICKS-th low tick. No further pulse follows while `wake_n` stays low.
- R3: A tick that samples `wake_n`=1 before the count completes restarts the local count from zero, so a low period shorter than LOC_TICKS ticks gives no pulse.
- R4: With `sleep_mode`=1, once the bus has been armed, sampling `bus_dom`=1 on BUS_TICKS consecutive ticks and then `bus_dom`=0 on the next tick makes `wake_lin` 1 for exactly one cycle. That cycle follows the edge that samples the recessive tick.
- R5: A dominant period shorter than BUS_TICKS ticks, ended by a recessive tick, gives no pulse, and the dominant count restarts.
- R6: A bus that stays dominant (`bus_dom`=1) on every tick never raises `wake_lin`, however long it lasts.
- R7: After `sleep_mode` rises, the bus is armed only by a tick that samples `bus_dom`=0. Dominant ticks before that tick do not count.
- R8: While `sleep_mode`=0, both outputs stay 0. A fall of `sleep_mode` discards all partial progress on both sources.
- R9: If both sources qualify on the same tick, `wake_lin` and `wake_local` are 1 in the same cycle.
- R10: Input values on cycles with `tick`=0 have no effect on either filter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase enable; inputs are sampled only when 1 |
| sleep_mode | input | 1 | 1 while the mode controller is in the low-power mode (arms the block) |
| bus_dom | input | 1 | Digitized bus level, 1 = dominant, 0 = recessive |
| wake_n | input | 1 | Local wake input, active low |
| wake_lin | output | 1 | One-cycle pulse: qualified remote wake |
| wake_local | output | 1 | One-cycle pulse: qualified local wake |

## Verification
The hardest case to reach from the ports is both sources completing on the same tick. To get there, the local low period must start exactly LOC_TICKS-1 ticks before the tick on which the bus returns to recessive. That recessive tick must follow a bus hold of at least BUS_TICKS ticks. The bench steps the design one tick at a time to set up this overlap. It also sets up a partial count that is cut short by leaving sleep and is then resumed after re-arming. That case shows progress is discarded, not frozen. A stuck-dominant bus held for many times the filter length covers the short-to-ground case.

// File: rtl/lwk_pkg.sv
package lwk_pkg;

  typedef enum logic [1:0] {
    BQ_WAIT_REC = 2'd0,
    BQ_ARMED    = 2'd1,
    BQ_COUNT    = 2'd2,
    BQ_HELD     = 2'd3
  } bq_state_t;

  function automatic int cnt_width(input int ticks);
    return (ticks < 2) ? 1 : $clog2(ticks + 1);
  endfunction

endpackage

// File: rtl/lwk_bus_qual.sv
module lwk_bus_qual
  import lwk_pkg::*;
#(
  parameter int TICKS = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic tick,
  input  logic dom,
  output logic fire
);

  localparam int CW = cnt_width(TICKS);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  bq_state_t      state;
  logic [CW-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (rst || !arm) begin
      state <= BQ_WAIT_REC;
      cnt   <= '0;
    end else if (tick) begin
      case (state)
        BQ_WAIT_REC: begin
          if (!dom) state <= BQ_ARMED;
        end
        BQ_ARMED: begin
          if (dom) begin
            if (LAST == '0) begin
              state <= BQ_HELD;
            end else begin
              state <= BQ_COUNT;
              cnt   <= CW'(1);
            end
          end
        end
        BQ_COUNT: begin
          if (!dom) begin
            state <= BQ_ARMED;
            cnt   <= '0;
          end else if (cnt == LAST) begin
            state <= BQ_HELD;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        BQ_HELD: begin
          if (!dom) state <= BQ_ARMED;
        end
        default: state <= BQ_WAIT_REC;
      endcase
    end
  end

  assign fire = arm && tick && !dom && (state == BQ_HELD);

  // R5: the dominant counter never runs past the filter length
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  // R4: the held state is reached only from a dominant tick while counting or armed
  p_held_entry_r4: assert property (@(posedge clk) disable iff (rst)
    (state == BQ_HELD && $past(state) != BQ_HELD) |->
      $past(tick && dom && arm));

  // R7: leaving the wait state needs a recessive tick
  p_arm_needs_rec_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == BQ_WAIT_REC && state != BQ_WAIT_REC) |->
      $past(tick && !dom));

endmodule

// File: rtl/lwk_local_qual.sv
module lwk_local_qual
  import lwk_pkg::*;
#(
  parameter int TICKS = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic tick,
  input  logic low,
  output logic fire
);

  localparam int CW = cnt_width(TICKS);
  localparam logic [CW-1:0] FULL = CW'(TICKS);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !arm) begin
      cnt <= '0;
    end else if (tick) begin
      if (!low)             cnt <= '0;
      else if (cnt != FULL) cnt <= cnt + CW'(1);
    end
  end

  assign fire = arm && tick && low && (cnt == LAST);

  // R3: a high sample on a tick always restarts the count
  p_restart_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(tick && !low)) |-> (cnt == '0));

  // R2: counter saturates at the filter length
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);

endmodule

// File: rtl/lin_wake_filter.sv
module lin_wake_filter #(
  parameter int BUS_TICKS = 50,
  parameter int LOC_TICKS = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic sleep_mode,
  input  logic bus_dom,
  input  logic wake_n,
  output logic wake_lin,
  output logic wake_local
);

  logic bus_fire;
  logic loc_fire;

  lwk_bus_qual #(.TICKS(BUS_TICKS)) i_bus (
    .clk  (clk),
    .rst  (rst),
    .arm  (sleep_mode),
    .tick (tick),
    .dom  (bus_dom),
    .fire (bus_fire)
  );

  lwk_local_qual #(.TICKS(LOC_TICKS)) i_loc (
    .clk  (clk),
    .rst  (rst),
    .arm  (sleep_mode),
    .tick (tick),
    .low  (!wake_n),
    .fire (loc_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_lin   <= 1'b0;
      wake_local <= 1'b0;
    end else begin
      wake_lin   <= bus_fire && sleep_mode;
      wake_local <= loc_fire && sleep_mode;
    end
  end

  // R8: no pulse is issued for an edge where the block was not armed
  p_quiet_unarmed_r8: assert property (@(posedge clk) disable iff (rst)
    !sleep_mode |=> (!wake_lin && !wake_local));

  // R4: a remote wake follows a recessive tick
  p_lin_on_rec_r4: assert property (@(posedge clk) disable iff (rst)
    wake_lin |-> $past(tick && !bus_dom));

  // R4: remote pulse lasts one cycle
  p_lin_single_r4: assert property (@(posedge clk) disable iff (rst)
    wake_lin |=> !wake_lin);

  // R2: a local wake follows a low tick and lasts one cycle
  p_loc_on_low_r2: assert property (@(posedge clk) disable iff (rst)
    wake_local |-> $past(tick && !wake_n));

  p_loc_single_r2: assert property (@(posedge clk) disable iff (rst)
    wake_local |=> !wake_local);

  // R1: outputs are clear right after reset
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (!wake_lin && !wake_local));

endmodule

// File: tb/test_lin_wake_filter.sv
module test_lin_wake_filter;

  localparam int BT = 5;
  localparam int LT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic sleep_mode = 1'b0;
  logic bus_dom = 1'b0;
  logic wake_n = 1'b1;
  logic wake_lin;
  logic wake_local;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  lin_wake_filter #(.BUS_TICKS(BT), .LOC_TICKS(LT)) i_lin_wake_filter (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .sleep_mode (sleep_mode),
    .bus_dom    (bus_dom),
    .wake_n     (wake_n),
    .wake_lin   (wake_lin),
    .wake_local (wake_local)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // one clock cycle: drive on negedge, sample shortly after posedge
  task automatic step(input logic t, input logic d, input logic wn);
    @(negedge clk);
    tick = t; bus_dom = d; wake_n = wn;
    @(posedge clk);
    #1;
  endtask

  task automatic idle_tick();
    step(1'b1, 1'b0, 1'b1);
  endtask

  task automatic rearm();
    @(negedge clk); sleep_mode = 1'b0; tick = 1'b0;
    @(negedge clk); sleep_mode = 1'b1;
    idle_tick();
  endtask

  task automatic t_reset();
    chk("R1 lin in reset", wake_lin, 1'b0);
    chk("R1 local in reset", wake_local, 1'b0);
    @(negedge clk); rst = 1'b0; sleep_mode = 1'b1;
    @(posedge clk); #1;
    chk("R1 lin after reset", wake_lin, 1'b0);
    chk("R1 local after reset", wake_local, 1'b0);
  endtask

  task automatic t_local_short();
    rearm();
    for (int i = 0; i < LT - 1; i++) begin
      step(1'b1, 1'b0, 1'b0);
      chk("R3 short low no pulse", wake_local, 1'b0);
    end
    idle_tick();
    for (int i = 0; i < LT - 1; i++) begin
      step(1'b1, 1'b0, 1'b0);
      chk("R3 restarted count no pulse", wake_local, 1'b0);
    end
    idle_tick();
    chk("R3 no pulse after release", wake_local, 1'b0);
  endtask

  task automatic t_local_full();
    rearm();
    for (int i = 0; i < LT; i++) begin
      step(1'b1, 1'b0, 1'b0);
      chk("R2 local pulse timing", wake_local, (i == LT - 1));
    end
    step(1'b0, 1'b0, 1'b0);
    chk("R2 local pulse one cycle", wake_local, 1'b0);
    for (int i = 0; i < 3 * LT; i++) begin
      step(1'b1, 1'b0, 1'b0);
      chk("R2 no repeat while low", wake_local, 1'b0);
    end
    chk("R2 bus side quiet", wake_lin, 1'b0);
    idle_tick();
  endtask

  task automatic t_bus_full();
    rearm();
    for (int i = 0; i < BT; i++) begin
      step(1'b1, 1'b1, 1'b1);
      chk("R4 no pulse while dominant", wake_lin, 1'b0);
    end
    step(1'b1, 1'b0, 1'b1);
    chk("R4 pulse on recessive tick", wake_lin, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    chk("R4 pulse one cycle", wake_lin, 1'b0);
    idle_tick();
    chk("R4 no second pulse", wake_lin, 1'b0);
  endtask

  task automatic t_bus_short();
    rearm();
    for (int i = 0; i < BT - 1; i++) step(1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b0, 1'b1);
    chk("R5 short dominant no pulse", wake_lin, 1'b0);
    for (int i = 0; i < BT - 1; i++) step(1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b0, 1'b1);
    chk("R5 restarted count no pulse", wake_lin, 1'b0);
  endtask

  task automatic t_bus_stuck();
    rearm();
    for (int i = 0; i < 20 * BT; i++) begin
      step(1'b1, 1'b1, 1'b1);
      if (wake_lin) chk("R6 stuck dominant", wake_lin, 1'b0);
    end
    chk("R6 stuck dominant end", wake_lin, 1'b0);
    step(1'b0, 1'b1, 1'b1);
    chk("R6 stuck dominant no tick", wake_lin, 1'b0);
  endtask

  task automatic t_arm_needs_rec();
    @(negedge clk); sleep_mode = 1'b0; tick = 1'b0;
    @(negedge clk); sleep_mode = 1'b1;
    for (int i = 0; i < BT; i++) step(1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b0, 1'b1);
    chk("R7 dominant before arming ignored", wake_lin, 1'b0);
    for (int i = 0; i < BT; i++) step(1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b0, 1'b1);
    chk("R7 armed after recessive tick", wake_lin, 1'b1);
  endtask

  task automatic t_unarmed();
    @(negedge clk); sleep_mode = 1'b0;
    idle_tick();
    for (int i = 0; i < BT; i++) step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    chk("R8 no lin while awake", wake_lin, 1'b0);
    chk("R8 no local while awake", wake_local, 1'b0);
    rearm();
    for (int i = 0; i < BT - 1; i++) step(1'b1, 1'b1, 1'b0);
    @(negedge clk); sleep_mode = 1'b0; tick = 1'b0;
    @(negedge clk); sleep_mode = 1'b1;
    idle_tick();
    step(1'b1, 1'b1, 1'b0);
    chk("R8 local progress discarded", wake_local, 1'b0);
    step(1'b1, 1'b0, 1'b1);
    chk("R8 bus progress discarded", wake_lin, 1'b0);
  endtask

  task automatic t_both();
    rearm();
    for (int i = 0; i < BT; i++) begin
      step(1'b1, 1'b1, (i < BT - (LT - 1)) ? 1'b1 : 1'b0);
      chk("R9 no early local", wake_local, 1'b0);
    end
    step(1'b1, 1'b0, 1'b0);
    chk("R9 lin together", wake_lin, 1'b1);
    chk("R9 local together", wake_local, 1'b1);
    idle_tick();
  endtask

  task automatic t_no_tick();
    rearm();
    for (int i = 0; i < 4 * LT; i++) begin
      step(1'b0, 1'b1, 1'b0);
      if (wake_local || wake_lin) chk("R10 activity without tick", 1'b1, 1'b0);
    end
    chk("R10 local untouched", wake_local, 1'b0);
    for (int i = 0; i < LT - 1; i++) begin
      step(1'b1, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b1);
    end
    step(1'b1, 1'b0, 1'b0);
    chk("R10 high between ticks ignored", wake_local, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_local_short();
    t_local_full();
    t_bus_full();
    t_bus_short();
    t_bus_stuck();
    t_arm_needs_rec();
    t_unarmed();
    t_both();
    t_no_tick();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule